// File: doc/BRIEF.md
# Predicated Saturating Rounding Vector Shifter

This block shifts a vector of unsigned 16-bit lanes. Each lane has its own amount, which is the signed 16-bit value in the same lane of a second vector. The sign of the amount sets the direction. A zero or positive amount shifts left, and any result too large for 16 bits is clamped to 0xFFFF. A negative amount shifts right by its magnitude, with rounding half up. The rounding sum is formed in 17 bits, so its carry is kept.

The destination vector is also the value that gets shifted. A predicate with one bit per byte of the vector picks the lanes that are written. Only the even bit of each two-bit pair counts, one pair per halfword lane. A lane whose predicate bit is clear keeps its old destination value. The block registers its results once, so they appear one cycle after a valid input. It also gives one saturation flag per lane and a sticky flag that is set when any active lane has saturated since reset.

The vector width is a parameter. It covers 128 to 2048 bits, which is 8 to 128 lanes.

Top module: `qrsVecShifter`

## Requirements
- R1: When a lane's amount is between 0 and 15 and no set bit moves past bit 15, the lane result is the operand shifted left by the amount, and the lane's saturation flag is 0.
- R2: When a left shift of 0 to 15 would move any set bit past bit 15, the lane result is 0xFFFF and the lane's saturation flag (laneSat bit i for lane i) is 1.
- R3: When a lane's amount is 16 or more, the result is 0 for a zero operand. For a nonzero operand the result is 0xFFFF and the saturation flag is set.
- R4: When a lane's amount is between -16 and -1 (magnitude n), the result is (operand + 2^(n-1)) >> n, computed in at least 17 bits. For example, 0x8000 shifted by -16 gives 1, and 0xFFFF shifted by -1 gives 0x8000. A right shift never sets the saturation flag.
- R5: When a lane's amount is -17 or less, including -32768, the lane result is 0.
- R6: Lane i (bits 16i+15 down to 16i) is written only when predicate bit 2i is 1. Otherwise it keeps its srcDst value and its saturation flag is 0. Predicate bit 2i+1 has no effect.
- R7: Results and flags are registered on a clock edge where inValid is high, and outValid is high in the cycle after. When inValid is low, outValid goes low, and result and laneSat hold their values.
- R8: satSticky goes to 1 on the edge that records any active lane saturating. It then stays at 1 until reset.
- R9: After reset, outValid, result, laneSat and satSticky are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Inputs are valid; capture the results at this edge |
| srcDst | input | VLEN | Old destination vector; also the operand vector |
| shiftAmt | input | VLEN | Signed 16-bit shift amount for each lane |
| predBytes | input | VLEN/8 | Predicate with one bit per byte; bit 2i enables lane i |
| outValid | output | 1 | result and laneSat hold a fresh operation |
| result | output | VLEN | Merged shifted vector |
| laneSat | output | VLEN/16 | Saturation flag for each lane |
| satSticky | output | 1 | Set when any active lane has saturated since reset |

## Verification
The edge amounts -17, -16, -1, 0, 15 and 16 are swept across lanes. They are paired with operands 0, 1, 2, 0x7FFF, 0x8000 and 0xFFFF. This pairing separates the rounding carry, the clamp at the 16-bit boundary and the zero-operand exception at large left shifts. A set of directed vectors covers -32768 and exact half-way rounding. Random amounts, mostly taken from -20 to 20, mix directions within one vector. Random predicates with the odd bits set against the even bits show whether the merge reads the correct byte bit. A run of idle cycles with the inputs changing, and a sequence of operations that first cannot saturate and then does, separate holding behaviour from the sticky flag.

// File: rtl/qrsPkg.sv
package qrsPkg;
  localparam int LANE_W = 16;

  typedef struct packed {
    logic capture;
    logic accumulate;
  } qrsStrobe_t;
endpackage

// File: rtl/qrsLane.sv
module qrsLane
  import qrsPkg::*;
(
  input  logic [LANE_W-1:0] opIn,
  input  logic [LANE_W-1:0] amtIn,
  output logic [LANE_W-1:0] resOut,
  output logic              satOut
);
  localparam int WIDE_W = 2 * LANE_W;
  localparam int SUM_W  = LANE_W + 1;
  localparam int SH_W   = $clog2(LANE_W) + 1;

  logic              amtNeg;
  logic              leftBig;
  logic [WIDE_W-1:0] leftWide;
  logic              leftLost;
  logic [SUM_W-1:0]  rightMag;
  logic              rightZero;
  logic [SH_W-1:0]   rightSh;
  logic [SUM_W-1:0]  roundAdd;
  logic [SUM_W-1:0]  roundSum;
  logic [SUM_W-1:0]  rightVal;

  assign amtNeg    = amtIn[LANE_W-1];
  assign leftBig   = |amtIn[LANE_W-2:SH_W-1];
  assign leftWide  = {{LANE_W{1'b0}}, opIn} << amtIn[SH_W-2:0];
  assign leftLost  = |leftWide[WIDE_W-1:LANE_W];
  assign rightMag  = SUM_W'(0) - {amtIn[LANE_W-1], amtIn};
  assign rightZero = rightMag > SUM_W'(LANE_W);
  assign rightSh   = rightMag[SH_W-1:0];
  assign roundAdd  = SUM_W'(1) << (rightSh - SH_W'(1));
  assign roundSum  = {1'b0, opIn} + roundAdd;
  assign rightVal  = roundSum >> rightSh;

  always_comb begin
    resOut = '0;
    satOut = 1'b0;
    if (amtNeg) begin
      if (!rightZero) resOut = rightVal[LANE_W-1:0];
    end else if (leftBig) begin
      satOut = |opIn;
      resOut = {LANE_W{satOut}};
    end else if (leftLost) begin
      satOut = 1'b1;
      resOut = '1;
    end else begin
      resOut = leftWide[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/qrsCtrl.sv
module qrsCtrl
  import qrsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output qrsStrobe_t strobe,
  output logic       outValid
);
  assign strobe.capture    = inValid;
  assign strobe.accumulate = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/qrsDatapath.sv
module qrsDatapath
  import qrsPkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  qrsStrobe_t        strobe,
  input  logic [VLEN-1:0]   srcDst,
  input  logic [VLEN-1:0]   shiftAmt,
  input  logic [VLEN/8-1:0] predBytes,
  output logic [VLEN-1:0]   result,
  output logic [VLEN/16-1:0] laneSat,
  output logic              satSticky
);
  localparam int LANES = VLEN / LANE_W;

  logic [VLEN-1:0]  nextRes;
  logic [LANES-1:0] nextSat;
  logic [LANES-1:0] oddPred;
  logic             unusedOddPred;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [LANE_W-1:0] cellRes;
    logic              cellSat;
    logic              laneOn;

    assign laneOn     = predBytes[2*i];
    assign oddPred[i] = predBytes[2*i+1];

    qrsLane uCell (
      .opIn   (srcDst[i*LANE_W +: LANE_W]),
      .amtIn  (shiftAmt[i*LANE_W +: LANE_W]),
      .resOut (cellRes),
      .satOut (cellSat)
    );

    assign nextRes[i*LANE_W +: LANE_W] = laneOn ? cellRes : srcDst[i*LANE_W +: LANE_W];
    assign nextSat[i] = laneOn & cellSat;

    a_r6_inactive_keeps: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && !predBytes[2*i]) |=>
        (result[i*LANE_W +: LANE_W] == $past(srcDst[i*LANE_W +: LANE_W]) && !laneSat[i]));
    a_r2_sat_gives_max: assert property (@(posedge clk) disable iff (!rstN)
      laneSat[i] |-> (result[i*LANE_W +: LANE_W] == '1));
    a_r4_right_no_sat: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capture && shiftAmt[i*LANE_W + LANE_W-1]) |=> !laneSat[i]);
  end

  assign unusedOddPred = ^oddPred;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      laneSat <= '0;
    end else if (strobe.capture) begin
      result  <= nextRes;
      laneSat <= nextSat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  satSticky <= 1'b0;
    else if (strobe.accumulate) satSticky <= satSticky | (|nextSat);
  end

  a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rstN)
    satSticky |=> satSticky);
  a_r8_sticky_covers: assert property (@(posedge clk) disable iff (!rstN)
    (|laneSat) |-> satSticky);
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(result) && $stable(laneSat)));
endmodule

// File: rtl/qrsVecShifter.sv
module qrsVecShifter
  import qrsPkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [VLEN-1:0]    srcDst,
  input  logic [VLEN-1:0]    shiftAmt,
  input  logic [VLEN/8-1:0]  predBytes,
  output logic               outValid,
  output logic [VLEN-1:0]    result,
  output logic [VLEN/16-1:0] laneSat,
  output logic               satSticky
);
  qrsStrobe_t strobe;

  qrsCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  qrsDatapath #(.VLEN(VLEN)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcDst    (srcDst),
    .shiftAmt  (shiftAmt),
    .predBytes (predBytes),
    .result    (result),
    .laneSat   (laneSat),
    .satSticky (satSticky)
  );
endmodule

// File: tb/tb_qrsVecShifter.sv
module tb_qrsVecShifter;
  localparam int VLEN  = 256;
  localparam int LANES = VLEN / 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic [VLEN-1:0]    srcDst = '0;
  logic [VLEN-1:0]    shiftAmt = '0;
  logic [VLEN/8-1:0]  predBytes = '0;
  logic               outValid;
  logic [VLEN-1:0]    result;
  logic [LANES-1:0]   laneSat;
  logic               satSticky;

  int checks = 0;
  int fails = 0;
  bit stickyExp = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qrsVecShifter #(.VLEN(VLEN)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcDst(srcDst),
    .shiftAmt(shiftAmt), .predBytes(predBytes), .outValid(outValid),
    .result(result), .laneSat(laneSat), .satSticky(satSticky)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int refRes(int op, int amt, output bit sat);
    longint v;
    int n;
    sat = 1'b0;
    if (amt >= 0) begin
      if (op == 0) return 0;
      if (amt >= 16) begin sat = 1'b1; return 65535; end
      v = longint'(op) * (longint'(1) << amt);
      if (v > 65535) begin sat = 1'b1; return 65535; end
      return int'(v);
    end
    n = -amt;
    if (n > 16) return 0;
    return (op + (1 << (n - 1))) / (1 << n);
  endfunction

  function automatic string tagOf(int amt, bit active, bit sat);
    if (!active) return "R6";
    if (amt < -16) return "R5";
    if (amt < 0) return "R4";
    if (amt >= 16) return "R3";
    return sat ? "R2" : "R1";
  endfunction

  task automatic runOp(logic [VLEN-1:0] s, logic [VLEN-1:0] a, logic [VLEN/8-1:0] p);
    bit anySat = 1'b0;
    @(negedge clk);
    srcDst = s; shiftAmt = a; predBytes = p; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 outValid", outValid, 1);
    for (int i = 0; i < LANES; i++) begin
      int op = int'(s[i*16 +: 16]);
      int amt = int'($signed(a[i*16 +: 16]));
      bit act = p[2*i];
      bit sat;
      int exp = refRes(op, amt, sat);
      if (!act) begin exp = op; sat = 1'b0; end
      anySat |= sat;
      check(tagOf(amt, act, sat), result[i*16 +: 16], exp);
      check({tagOf(amt, act, sat), " sat"}, laneSat[i], sat);
    end
    stickyExp |= anySat;
    check("R8 sticky", satSticky, stickyExp);
  endtask

  task automatic edgeSweep(int opA, int opB);
    int amts[6] = '{-17, -16, -1, 0, 15, 16};
    logic [VLEN-1:0] s, a;
    for (int i = 0; i < LANES; i++) begin
      s[i*16 +: 16] = 16'((i % 2) ? opB : opA);
      a[i*16 +: 16] = 16'(amts[i % 6]);
    end
    runOp(s, a, '1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] s, a;
    logic [VLEN/8-1:0] p;
    logic [VLEN-1:0] heldRes;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 outValid", outValid, 0);
    check("R9 result", result != 0, 0);
    check("R9 laneSat", laneSat, 0);
    check("R9 sticky", satSticky, 0);
    rstN = 1'b1;

    // R8: right shifts only, sticky must stay clear
    for (int i = 0; i < LANES; i++) begin
      s[i*16 +: 16] = 16'hFFFF - 16'(i * 97);
      a[i*16 +: 16] = 16'(-(i % 17) - 1);
    end
    runOp(s, a, '1);
    check("R8 sticky still clear", satSticky, 0);

    // Directed corner vectors R1..R5
    s = '0; a = '0;
    s[0*16 +: 16] = 16'h8000; a[0*16 +: 16] = 16'(-16);
    s[1*16 +: 16] = 16'hFFFF; a[1*16 +: 16] = 16'(-1);
    s[2*16 +: 16] = 16'h0000; a[2*16 +: 16] = 16'd16;
    s[3*16 +: 16] = 16'h0001; a[3*16 +: 16] = 16'd15;
    s[4*16 +: 16] = 16'h0002; a[4*16 +: 16] = 16'd15;
    s[5*16 +: 16] = 16'hFFFF; a[5*16 +: 16] = 16'h8000;
    s[6*16 +: 16] = 16'h0003; a[6*16 +: 16] = 16'(-1);
    s[7*16 +: 16] = 16'h0005; a[7*16 +: 16] = 16'h7FFF;
    s[8*16 +: 16] = 16'h7FFF; a[8*16 +: 16] = 16'(-16);
    s[9*16 +: 16] = 16'h1234; a[9*16 +: 16] = 16'd0;
    runOp(s, a, '1);
    check("R4 0x8000>>16", result[15:0], 16'h0001);
    check("R4 0xFFFF>>1", result[31:16], 16'h8000);
    check("R3 zero<<16", result[47:32], 0);
    check("R2 sticky set", satSticky, 1);

    // Edge amount sweeps
    edgeSweep(0, 1);
    edgeSweep(2, 16'h7FFF);
    edgeSweep(16'h8000, 16'hFFFF);

    // R6 predicate: odd bits opposite to even bits
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < LANES; i++) begin
        s[i*16 +: 16] = 16'($urandom);
        a[i*16 +: 16] = 16'($urandom_range(0, 40) - 20);
        p[2*i] = 1'($urandom);
        p[2*i+1] = ~p[2*i];
      end
      runOp(s, a, p);
    end

    // R7 hold while idle with changing inputs
    heldRes = result;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      srcDst = {(VLEN/32){32'($urandom)}};
      shiftAmt = '0;
      predBytes = '1;
      @(negedge clk);
      check("R7 idle outValid", outValid, 0);
      check("R7 idle hold", result == heldRes, 1);
    end

    // Random mixed traffic
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < LANES; i++) begin
        s[i*16 +: 16] = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom);
        a[i*16 +: 16] = ($urandom_range(0, 9) == 0) ? 16'($urandom)
                                                  : 16'($urandom_range(0, 40) - 20);
      end
      p = VLEN'(0) | {(VLEN/32){4'($urandom)}};
      runOp(s, a, p);
    end

    // R8 sticky survives a non-saturating op
    for (int i = 0; i < LANES; i++) begin
      s[i*16 +: 16] = 16'd7;
      a[i*16 +: 16] = 16'd1;
    end
    runOp(s, a, '1);
    check("R8 sticky holds", satSticky, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule